// File: doc/BRIEF.md
# Indexed Socket Register Front End

This block is the host-facing register file of a controller that serves up to four card sockets, two by default. The host sees only two byte-wide I/O locations. It first writes an index byte to the lower location. It then reads or writes the register that byte selects through the upper location. The top two bits of the index pick the socket and the low six bits pick one of 64 register slots inside that socket.

Each implemented socket has four live slots. Slot 0 returns a fixed identification code. Slot 1 shows the synchronized card pins. Slot 2 holds the power controls and slot 3 holds the reset and card-type controls. The stored control bits are exported as decoded per-socket outputs, which the power-switch and card-bus logic elsewhere on the chip consume. Reads are combinational from the current index and state. Writes take effect on the rising clock edge at which the select and write strobes are high.

Top module: `sock_reg_front`

## Requirements
- R1: The index byte is written when `busSel`, `busWr` are high and `busAddr` is 0. It reads back unchanged from `busAddr` 0. It is 0x00 after reset and changes on no other access.
- R2: Index bits 7:6 select the socket and bits 5:0 select the register. Data accesses to a socket number at or above `SOCKETS` read 0x00 and change nothing.
- R3: Register 0x00 of every implemented socket reads 0x83 (`ID_VALUE`), and writes to it are ignored.
- R4: Register 0x01 reads the socket's pins as: bit 7 = 0, bit 6 = power active, bit 5 = ready, bit 4 = write protect, bits 3:2 = the two card-detect inputs, bits 1:0 = the two battery-detect inputs. Writes to it are ignored.
- R5: Register 0x02 stores bit 7 (output enable), bit 5 (auto power switch), bit 4 (Vcc enable) and bits 1:0 (Vpp select, 01 = 5 V, 10 = 12 V). Bits 6, 3 and 2 read 0. The stored fields drive `sockOutEn`, `sockAutoPwr`, `sockVccEn` and `sockVpp`.
- R6: Register 0x03 stores bit 6 (1 = card out of reset) and bit 5 (1 = I/O card, 0 = memory card). All other bits read 0. The stored fields drive `sockResetN` and `sockIoType`.
- R7: Register numbers 0x04 to 0x3F read 0x00, and writes to them change no readable register and no output.
- R8: A card pin change at the socket inputs shows up in register 0x01 after exactly two rising clock edges, not after one.
- R9: After reset every writable register is 0x00, so every socket has output enable, Vcc and Vpp off and card reset asserted.
- R10: `busRdata` is 0x00 whenever `busSel` and `busRd` are not both high.
- R11: A data write changes only the socket that the index selects. The other sockets keep their register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Host access select |
| busAddr | input | 1 | 0 = index location, 1 = data location |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| pinPwrActive | input | SOCKETS | Card power-good pin per socket |
| pinReady | input | SOCKETS | Ready/not-busy pin per socket |
| pinWp | input | SOCKETS | Write-protect pin per socket |
| pinDetect | input | 2*SOCKETS | Two card-detect pins per socket |
| pinBvd | input | 2*SOCKETS | Two battery-detect pins per socket |
| sockOutEn | output | SOCKETS | Output enable per socket |
| sockAutoPwr | output | SOCKETS | Auto power switch per socket |
| sockVccEn | output | SOCKETS | Vcc enable per socket |
| sockVpp | output | 2*SOCKETS | Vpp select per socket |
| sockResetN | output | SOCKETS | Card reset, low = held in reset |
| sockIoType | output | SOCKETS | Card type, 1 = I/O |

## Verification
The bench aims at the decode edges. It uses socket numbers 2 and 3, which have no hardware behind them; a design that failed to gate them would alias onto sockets 0 and 1 and corrupt their controls. It writes all-ones bytes to the identification, status and unused slots, which exposes a decoder that stores into read-only or reserved locations, as well as a mask that lets bits 6, 3 or 2 of the power byte stick. The pin path is timed edge by edge, so a synchronizer with one stage or three stages shows the new value one cycle early or one cycle late. A random phase mixes index and data writes across sockets with reads and compares each read against a bench model, which catches cross-socket writes.

// File: rtl/sock_reg_pkg.sv
package sock_reg_pkg;
  localparam int SOCK_BITS = 2;
  localparam int REG_BITS  = 6;
  localparam int MAX_SOCK  = 1 << SOCK_BITS;
  localparam int STAT_W    = 7;

  localparam logic [REG_BITS-1:0] REG_ID   = 6'h00;
  localparam logic [REG_BITS-1:0] REG_STAT = 6'h01;
  localparam logic [REG_BITS-1:0] REG_PWR  = 6'h02;
  localparam logic [REG_BITS-1:0] REG_GEN  = 6'h03;

  typedef enum logic [2:0] {
    RD_ZERO, RD_INDEX, RD_ID, RD_STAT, RD_PWR, RD_GEN
  } rdSel_e;

  typedef struct packed {
    logic                idxWr;
    logic                pwrWr;
    logic                genWr;
    logic [MAX_SOCK-1:0] sockHot;
    rdSel_e              rdSel;
  } strobe_t;
endpackage

// File: rtl/sock_reg_ctrl.sv
module sock_reg_ctrl
  import sock_reg_pkg::*;
#(
  parameter int SOCKETS = 2
) (
  input  logic       busSel,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] indexQ,
  output strobe_t    strb
);
  logic [SOCK_BITS-1:0] sockNum;
  logic [REG_BITS-1:0]  regNum;
  logic sockOk, doWr, doRd, dataWr;

  assign sockNum = indexQ[7:8-SOCK_BITS];
  assign regNum  = indexQ[REG_BITS-1:0];
  assign sockOk  = int'(sockNum) < SOCKETS;
  assign doWr    = busSel & busWr;
  assign doRd    = busSel & busRd;
  assign dataWr  = doWr & busAddr & sockOk;

  always_comb begin
    strb.idxWr   = doWr & ~busAddr;
    strb.pwrWr   = dataWr && (regNum == REG_PWR);
    strb.genWr   = dataWr && (regNum == REG_GEN);
    strb.sockHot = sockOk ? (MAX_SOCK'(1) << sockNum) : '0;
    if (!doRd)        strb.rdSel = RD_ZERO;
    else if (!busAddr) strb.rdSel = RD_INDEX;
    else if (!sockOk)  strb.rdSel = RD_ZERO;
    else begin
      case (regNum)
        REG_ID:   strb.rdSel = RD_ID;
        REG_STAT: strb.rdSel = RD_STAT;
        REG_PWR:  strb.rdSel = RD_PWR;
        REG_GEN:  strb.rdSel = RD_GEN;
        default:  strb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/sock_reg_dp.sv
module sock_reg_dp
  import sock_reg_pkg::*;
#(
  parameter int          SOCKETS     = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ID_VALUE    = 8'h83
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [7:0]           busWdata,
  output logic [7:0]           indexQ,
  output logic [7:0]           rdData,
  input  logic [SOCKETS-1:0]   pinPwrActive,
  input  logic [SOCKETS-1:0]   pinReady,
  input  logic [SOCKETS-1:0]   pinWp,
  input  logic [2*SOCKETS-1:0] pinDetect,
  input  logic [2*SOCKETS-1:0] pinBvd,
  output logic [SOCKETS-1:0]   sockOutEn,
  output logic [SOCKETS-1:0]   sockAutoPwr,
  output logic [SOCKETS-1:0]   sockVccEn,
  output logic [2*SOCKETS-1:0] sockVpp,
  output logic [SOCKETS-1:0]   sockResetN,
  output logic [SOCKETS-1:0]   sockIoType
);
  logic [7:0] statByte [SOCKETS];
  logic [7:0] pwrByte  [SOCKETS];
  logic [7:0] genByte  [SOCKETS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           indexQ <= '0;
    else if (strb.idxWr) indexQ <= busWdata;
  end

  for (genvar s = 0; s < SOCKETS; s++) begin : g_sock
    logic [STAT_W-1:0] syncQ [SYNC_STAGES];
    logic [STAT_W-1:0] rawPins;
    logic [4:0] pwrQ;
    logic [1:0] genQ;

    assign rawPins = {pinPwrActive[s], pinReady[s], pinWp[s],
                      pinDetect[2*s +: 2], pinBvd[2*s +: 2]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      end else begin
        syncQ[0] <= rawPins;
        for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwrQ <= '0;
        genQ <= '0;
      end else begin
        if (strb.pwrWr && strb.sockHot[s])
          pwrQ <= {busWdata[7], busWdata[5], busWdata[4], busWdata[1:0]};
        if (strb.genWr && strb.sockHot[s])
          genQ <= busWdata[6:5];
      end
    end

    assign statByte[s]      = {1'b0, syncQ[SYNC_STAGES-1]};
    assign pwrByte[s]       = {pwrQ[4], 1'b0, pwrQ[3], pwrQ[2], 2'b00, pwrQ[1:0]};
    assign genByte[s]       = {1'b0, genQ, 5'b0};
    assign sockOutEn[s]     = pwrQ[4];
    assign sockAutoPwr[s]   = pwrQ[3];
    assign sockVccEn[s]     = pwrQ[2];
    assign sockVpp[2*s +: 2] = pwrQ[1:0];
    assign sockResetN[s]    = genQ[1];
    assign sockIoType[s]    = genQ[0];
  end

  always_comb begin
    logic [7:0] selStat, selPwr, selGen;
    selStat = '0;
    selPwr  = '0;
    selGen  = '0;
    for (int s = 0; s < SOCKETS; s++) begin
      if (strb.sockHot[s]) begin
        selStat = statByte[s];
        selPwr  = pwrByte[s];
        selGen  = genByte[s];
      end
    end
    case (strb.rdSel)
      RD_INDEX: rdData = indexQ;
      RD_ID:    rdData = ID_VALUE;
      RD_STAT:  rdData = selStat;
      RD_PWR:   rdData = selPwr;
      RD_GEN:   rdData = selGen;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/sock_reg_front.sv
module sock_reg_front
  import sock_reg_pkg::*;
#(
  parameter int         SOCKETS     = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_VALUE    = 8'h83
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  input  logic [SOCKETS-1:0]   pinPwrActive,
  input  logic [SOCKETS-1:0]   pinReady,
  input  logic [SOCKETS-1:0]   pinWp,
  input  logic [2*SOCKETS-1:0] pinDetect,
  input  logic [2*SOCKETS-1:0] pinBvd,
  output logic [SOCKETS-1:0]   sockOutEn,
  output logic [SOCKETS-1:0]   sockAutoPwr,
  output logic [SOCKETS-1:0]   sockVccEn,
  output logic [2*SOCKETS-1:0] sockVpp,
  output logic [SOCKETS-1:0]   sockResetN,
  output logic [SOCKETS-1:0]   sockIoType
);
  strobe_t    strb;
  logic [7:0] indexQ;

  sock_reg_ctrl #(.SOCKETS(SOCKETS)) u_ctrl (
    .busSel(busSel), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .indexQ(indexQ), .strb(strb)
  );

  sock_reg_dp #(.SOCKETS(SOCKETS), .SYNC_STAGES(SYNC_STAGES), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .indexQ(indexQ), .rdData(busRdata),
    .pinPwrActive(pinPwrActive), .pinReady(pinReady), .pinWp(pinWp),
    .pinDetect(pinDetect), .pinBvd(pinBvd),
    .sockOutEn(sockOutEn), .sockAutoPwr(sockAutoPwr), .sockVccEn(sockVccEn),
    .sockVpp(sockVpp), .sockResetN(sockResetN), .sockIoType(sockIoType)
  );
endmodule

// File: rtl/sock_reg_front_chk.sv
module sock_reg_front_chk #(
  parameter int         SOCKETS  = 2,
  parameter logic [7:0] ID_VALUE = 8'h83
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busAddr,
  input logic                 busWr,
  input logic                 busRd,
  input logic [7:0]           busWdata,
  input logic [7:0]           busRdata,
  input logic [7:0]           indexQ,
  input logic [SOCKETS-1:0]   sockOutEn,
  input logic [SOCKETS-1:0]   sockVccEn,
  input logic [2*SOCKETS-1:0] sockVpp,
  input logic [SOCKETS-1:0]   sockResetN,
  input logic [SOCKETS-1:0]   sockIoType
);
  logic idxWrite, dataRead, dataWrite, sockOk;
  assign idxWrite  = busSel && busWr && !busAddr;
  assign dataRead  = busSel && busRd && busAddr;
  assign dataWrite = busSel && busWr && busAddr;
  assign sockOk    = int'(indexQ[7:6]) < SOCKETS;

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxWrite |=> indexQ == $past(busWdata));

  // R1
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idxWrite |=> $stable(indexQ));

  // R3
  id_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && sockOk && indexQ[5:0] == 6'h00) |-> busRdata == ID_VALUE);

  // R4
  stat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && indexQ[5:0] == 6'h01) |-> !busRdata[7]);

  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && indexQ[5:0] > 6'h03) |-> busRdata == 8'h00);

  // R2
  absent_sock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !sockOk) |-> busRdata == 8'h00);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busRd) |-> busRdata == 8'h00);

  // R5
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrite |=> ($stable(sockOutEn) && $stable(sockVccEn) && $stable(sockVpp)));

  // R6
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrite |=> ($stable(sockResetN) && $stable(sockIoType)));
endmodule

bind sock_reg_front sock_reg_front_chk #(.SOCKETS(SOCKETS), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr), .busWr(busWr),
  .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .indexQ(indexQ),
  .sockOutEn(sockOutEn), .sockVccEn(sockVccEn), .sockVpp(sockVpp),
  .sockResetN(sockResetN), .sockIoType(sockIoType)
);

// File: tb/sock_reg_front_bench.sv
module sock_reg_front_bench;
  localparam int S = 2;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busAddr = 0, busWr = 0, busRd = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic [S-1:0] pinPwrActive = 0, pinReady = 0, pinWp = 0;
  logic [2*S-1:0] pinDetect = 0, pinBvd = 0;
  logic [S-1:0] sockOutEn, sockAutoPwr, sockVccEn, sockResetN, sockIoType;
  logic [2*S-1:0] sockVpp;

  int total = 0, bad = 0;
  logic [7:0] mIdx;
  logic [7:0] mPwr [S];
  logic [7:0] mGen [S];

  always #5 clk = ~clk;

  sock_reg_front u_sock_reg_front (.*);

  function automatic logic [7:0] pinByte(int s);
    return {1'b0, pinPwrActive[s], pinReady[s], pinWp[s], pinDetect[2*s +: 2], pinBvd[2*s +: 2]};
  endfunction

  function automatic logic [7:0] expData(logic [7:0] idx);
    int s = int'(idx[7:6]);
    if (s >= S) return 8'h00;
    case (idx[5:0])
      6'h00: return 8'h83;
      6'h01: return pinByte(s);
      6'h02: return mPwr[s];
      6'h03: return mGen[s];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
    if (!a) mIdx = d;
    else if (int'(mIdx[7:6]) < S) begin
      if (mIdx[5:0] == 6'h02) mPwr[mIdx[7:6]] = d & 8'hB3;
      if (mIdx[5:0] == 6'h03) mGen[mIdx[7:6]] = d & 8'h60;
    end
  endtask

  task automatic rdChk(logic a, string req);
    logic [7:0] got;
    @(negedge clk);
    busSel = 1; busRd = 1; busAddr = a;
    #1 got = busRdata;
    check(req, got, a ? expData(mIdx) : mIdx);
    @(posedge clk); #1;
    busSel = 0; busRd = 0;
  endtask

  task automatic outChk(string req);
    for (int s = 0; s < S; s++) begin
      check(req, {sockOutEn[s], 1'b0, sockAutoPwr[s], sockVccEn[s], 2'b0, sockVpp[2*s +: 2]}, mPwr[s]);
      check(req, {1'b0, sockResetN[s], sockIoType[s], 5'b0}, mGen[s]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'd1234));
    mIdx = 0;
    for (int s = 0; s < S; s++) begin mPwr[s] = 0; mGen[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R9 reset state of outputs and registers; R1 index reset
    outChk("R9");
    rdChk(0, "R1");
    // R10 idle read bus
    #1 check("R10", busRdata, 8'h00);

    // R3 id, write ignored
    wr(0, 8'h00); wr(1, 8'hFF); rdChk(1, "R3");
    wr(0, 8'h40); rdChk(1, "R3");
    // R1 index readback
    rdChk(0, "R1");

    // R5 power masking
    wr(0, 8'h02); wr(1, 8'hFF); rdChk(1, "R5"); outChk("R5");
    // R11 other socket untouched
    wr(0, 8'h42); rdChk(1, "R11");
    wr(1, 8'h92); rdChk(1, "R5"); outChk("R11");
    // R6 gen control
    wr(0, 8'h03); wr(1, 8'hFF); rdChk(1, "R6"); outChk("R6");
    wr(0, 8'h43); wr(1, 8'h20); rdChk(1, "R6"); outChk("R6");

    // R7 unused slots
    wr(0, 8'h04); wr(1, 8'hFF); rdChk(1, "R7");
    wr(0, 8'h7F); wr(1, 8'hFF); rdChk(1, "R7"); outChk("R7");
    // R2 absent sockets 2 and 3 alias nothing
    wr(0, 8'h82); wr(1, 8'h00); rdChk(1, "R2");
    wr(0, 8'hC3); wr(1, 8'h00); rdChk(1, "R2");
    wr(0, 8'h80); rdChk(1, "R2"); outChk("R2");

    // R4 status layout and write ignore
    wr(0, 8'h01); wr(1, 8'hFF);
    @(negedge clk);
    pinPwrActive = 2'b01; pinReady = 2'b00; pinWp = 2'b01; pinDetect = 4'b0010; pinBvd = 4'b1101;
    repeat (3) @(posedge clk);
    rdChk(1, "R4");
    wr(0, 8'h41); rdChk(1, "R4");

    // R8 two-edge synchronizer timing on socket 1
    @(negedge clk);
    busSel = 1; busRd = 1; busAddr = 1;
    pinReady = 2'b10; pinDetect = 4'b1110;
    @(posedge clk); @(negedge clk); #1 got = busRdata;
    check("R8", got, {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11});
    @(posedge clk); @(negedge clk); #1 got = busRdata;
    check("R8", got, pinByte(1));
    busSel = 0; busRd = 0;

    // random mix checked against model
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] v = 8'($urandom);
      if (op == 0) wr(0, {v[7:6], 4'b0, v[1:0]});
      else if (op == 1) wr(1, v);
      else if (op == 2) rdChk(1, "R11");
      else rdChk(0, "R1");
    end
    outChk("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule